// File: doc/BRIEF.md
# Multi-Stream Pattern Word Aligner

This block takes deserialized sample pairs from several time-interleaved converters. All of them have already been brought onto one fabric clock. Each converter's two internal cores deliver one sample each per fabric cycle. Before the converters are synchronized, a stream can start on either core, so the order of the two samples in a pair is unknown. A stream can also be skewed by up to a full cycle against its neighbours.

While the `train` input is high, every converter sends a known test sequence built from two words. Each word fills both samples of a pair, and the two words alternate from one cycle to the next. For each stream, the aligner tries three sample offsets (0, 1 and 2 samples) against a free-running reference word phase. It declares the stream locked once one offset has matched for a set number of consecutive cycles. That offset is then frozen.

Every stream passes through the same selection mux and one output register. All streams therefore leave the block on one common reference timeline with equal latency. A stream that fails to lock before a timeout is flagged as an error, and its output valid stays low.

Top module: `pattern_word_aligner`

## Requirements
- R1: After reset, `lock`, `err` and `out_valid` are all zero for every stream, and they stay zero until a training run locks a stream.
- R2: Clock edges are counted from 1, starting with the first edge after reset release. The pair captured at edge J stands in the reference timeline for sample indices 2J (low half, first sample) and 2J+1 (high half). The reference test content at index m is `PAT_A` when m mod 4 is 0 or 1, and `PAT_B` otherwise. A stream is "ahead by e" when its sample at index n carries the reference content of index n+e. A stream ahead by 0, 1 or 2 samples locks. A stream ahead by 3 never locks.
- R3: Let edge T be the first edge that samples `train` high after it was low. With the test content applied from edge T, a stream ahead by 0 shows `lock` after edge T+LOCK_CNT. A stream ahead by 1 or 2 shows `lock` after edge T+LOCK_CNT+1. No stream shows `lock` after edge T+LOCK_CNT-1.
- R4: A stream that has not locked while `train` stays high shows `err` after edge T+TIMEOUT+1. It does not show `err` after edge T+TIMEOUT.
- R5: A stream with `err` set has `lock` low and `out_valid` low.
- R6: For a locked stream, `out_pairs` after edge J holds reference sample 2(J-1) in the low half and 2J-1 in the high half. This holds both during training and afterwards, so all locked streams output the same reference samples in the same cycle.
- R7: `out_valid` after edge J equals `lock` after edge J-1.
- R8: While `train` is low, the chosen offset is frozen. If a stream's skew grows by d samples, its output shifts to reference samples 2(J-1)+d and 2J-1+d.
- R9: At edge T, a new training run clears `lock` and `err` for every stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train | input | 1 | High while converters send the test sequence |
| in_pairs | input | STREAMS*2*W | Per-stream sample pair; stream s occupies bits [s*2W +: 2W], first sample in the low half |
| out_pairs | output | STREAMS*2*W | Aligned per-stream pairs, same layout as the input |
| out_valid | output | STREAMS | Per-stream valid for `out_pairs` |
| lock | output | STREAMS | Per-stream lock flag |
| err | output | STREAMS | Per-stream lock timeout flag |

## Verification
The bench builds four 8-bit streams with LOCK_CNT 4 and TIMEOUT 40, which keeps each training run short enough to run several times. Across four training runs, each stream is rotated through all four skews (0 to 3 samples ahead). Every stream therefore meets every offset, the unmatchable skew and the error path, with exact lock and timeout edges. After each run, the bench switches to counting data and checks equal-latency output. It then changes every stream's skew to confirm that the frozen offset is kept.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
   localparam int unsigned NUM_OFF = 3;
   localparam int unsigned OFF_W   = 2;
   typedef logic [OFF_W-1:0] off_t;
endpackage

// File: rtl/pwa_history.sv
module pwa_history
   import pwa_pkg::*;
#(
   parameter int unsigned W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*W-1:0]       pair_in,
   output logic [NUM_OFF*W-1:0] cand_first,
   output logic [NUM_OFF*W-1:0] cand_second
);
   localparam int unsigned PW = 2 * W;

   logic [PW-1:0]   h0;
   logic [PW-1:0]   h1;
   logic [2*PW-1:0] win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h0 <= '0;
         h1 <= '0;
      end else begin
         h0 <= pair_in;
         h1 <= h0;
      end
   end

   // sample slots oldest first: 0 = h1 first, 1 = h1 second, 2 = h0 first, 3 = h0 second
   assign win = {h0, h1};

   for (genvar k = 0; k < NUM_OFF; k++) begin : g_cand
      assign cand_first[k*W +: W]  = win[(NUM_OFF-1-k)*W +: W];
      assign cand_second[k*W +: W] = win[(NUM_OFF-k)*W +: W];
   end
endmodule

// File: rtl/pwa_train_ctl.sv
module pwa_train_ctl #(
   parameter int unsigned TIMEOUT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic train,
   output logic start,
   output logic search,
   output logic timeout_hit,
   output logic ref_ph
);
   localparam int unsigned TW = $clog2(TIMEOUT + 1);

   logic          train_q;
   logic [TW-1:0] tcnt;

   assign start       = train & ~train_q;
   assign search      = train & train_q;
   assign timeout_hit = (tcnt == TW'(TIMEOUT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         train_q <= 1'b0;
         ref_ph  <= 1'b0;
         tcnt    <= '0;
      end else begin
         train_q <= train;
         ref_ph  <= ~ref_ph;
         if (start)
            tcnt <= '0;
         else if (train && !timeout_hit)
            tcnt <= tcnt + TW'(1);
      end
   end

   AST_TIMEOUT_NEEDS_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_hit && !$past(timeout_hit)) |-> $past(train)); // R4
endmodule

// File: rtl/pwa_lock_tracker.sv
module pwa_lock_tracker
   import pwa_pkg::*;
#(
   parameter int unsigned LOCK_CNT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               search,
   input  logic               timeout_hit,
   input  logic [NUM_OFF-1:0] match,
   output logic               locked,
   output logic               err,
   output off_t               off
);
   localparam int unsigned RW = $clog2(LOCK_CNT + 1);

   logic [RW-1:0] run_q;
   logic [RW-1:0] run_nxt;
   off_t          hit_k;
   logic          any_hit;
   logic          lock_now;

   always_comb begin
      hit_k   = '0;
      any_hit = 1'b0;
      for (int k = NUM_OFF - 1; k >= 0; k--) begin
         if (match[k]) begin
            hit_k   = off_t'(k);
            any_hit = 1'b1;
         end
      end
      if (!any_hit)
         run_nxt = '0;
      else if (run_q != '0 && hit_k == off)
         run_nxt = run_q + RW'(1);
      else
         run_nxt = RW'(1);
      lock_now = any_hit && (run_nxt == RW'(LOCK_CNT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
         err    <= 1'b0;
         off    <= '0;
         run_q  <= '0;
      end else if (clear) begin
         locked <= 1'b0;
         err    <= 1'b0;
         off    <= '0;
         run_q  <= '0;
      end else if (search && !locked && !err) begin
         run_q <= run_nxt;
         if (any_hit)
            off <= hit_k;
         if (lock_now)
            locked <= 1'b1;
         else if (timeout_hit)
            err <= 1'b1;
      end
   end

   AST_LOCK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked && err)); // R5
   AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !clear) |=> $stable(off)); // R8
   AST_LOCK_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(|match)); // R3
   AST_ERR_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(timeout_hit)); // R4
   AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      off < off_t'(NUM_OFF)); // R2
endmodule

// File: rtl/pattern_word_aligner.sv
module pattern_word_aligner
   import pwa_pkg::*;
#(
   parameter int unsigned STREAMS  = 4,
   parameter int unsigned W        = 12,
   parameter int unsigned LOCK_CNT = 8,
   parameter int unsigned TIMEOUT  = 64,
   parameter logic [W-1:0] PAT_A   = W'('h5A5),
   parameter logic [W-1:0] PAT_B   = W'('hA5A),
   parameter bit           OUT_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   train,
   input  logic [STREAMS*2*W-1:0] in_pairs,
   output logic [STREAMS*2*W-1:0] out_pairs,
   output logic [STREAMS-1:0]     out_valid,
   output logic [STREAMS-1:0]     lock,
   output logic [STREAMS-1:0]     err
);
   localparam int unsigned PW = 2 * W;

   if (STREAMS < 1 || W < 1) begin : g_bad_size
      initial $fatal(1, "pattern_word_aligner: STREAMS and W must be at least 1");
   end
   if (PAT_A == PAT_B) begin : g_bad_pattern
      initial $fatal(1, "pattern_word_aligner: the two test words must differ");
   end
   if (LOCK_CNT < 1 || TIMEOUT <= LOCK_CNT + 1) begin : g_bad_timing
      initial $fatal(1, "pattern_word_aligner: need 1 <= LOCK_CNT and TIMEOUT > LOCK_CNT + 1");
   end

   logic         start;
   logic         search;
   logic         timeout_hit;
   logic         ref_ph;
   logic [W-1:0] exp_word;

   pwa_train_ctl #(.TIMEOUT(TIMEOUT)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .train       (train),
      .start       (start),
      .search      (search),
      .timeout_hit (timeout_hit),
      .ref_ph      (ref_ph)
   );

   assign exp_word = ref_ph ? PAT_B : PAT_A;

   for (genvar s = 0; s < STREAMS; s++) begin : g_stream
      logic [NUM_OFF*W-1:0] cand_f;
      logic [NUM_OFF*W-1:0] cand_s;
      logic [NUM_OFF-1:0]   match;
      off_t                 off;
      logic [PW-1:0]        sel;

      pwa_history #(.W(W)) u_hist (
         .clk         (clk),
         .rst_n       (rst_n),
         .pair_in     (in_pairs[s*PW +: PW]),
         .cand_first  (cand_f),
         .cand_second (cand_s)
      );

      for (genvar k = 0; k < NUM_OFF; k++) begin : g_cmp
         assign match[k] = (cand_f[k*W +: W] == exp_word) && (cand_s[k*W +: W] == exp_word);
      end

      pwa_lock_tracker #(.LOCK_CNT(LOCK_CNT)) u_trk (
         .clk         (clk),
         .rst_n       (rst_n),
         .clear       (start),
         .search      (search),
         .timeout_hit (timeout_hit),
         .match       (match),
         .locked      (lock[s]),
         .err         (err[s]),
         .off         (off)
      );

      always_comb begin
         sel = '0;
         for (int k = 0; k < NUM_OFF; k++) begin
            if (off == off_t'(k))
               sel = {cand_s[k*W +: W], cand_f[k*W +: W]};
         end
      end

      if (OUT_REG) begin : g_reg
         logic [PW-1:0] pair_q;
         logic          vld_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pair_q <= '0;
               vld_q  <= 1'b0;
            end else begin
               pair_q <= sel;
               vld_q  <= lock[s];
            end
         end
         assign out_pairs[s*PW +: PW] = pair_q;
         assign out_valid[s]          = vld_q;

         AST_VALID_TRACKS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q == $past(lock[s])); // R7
      end else begin : g_comb
         assign out_pairs[s*PW +: PW] = sel;
         assign out_valid[s]          = lock[s];
      end

      AST_VALID_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[s] |-> !err[s]); // R5
   end
endmodule

// File: tb/sim_pattern_word_aligner.sv
module sim_pattern_word_aligner;
   localparam int N  = 4;
   localparam int W  = 8;
   localparam int LC = 4;
   localparam int TO = 40;
   localparam logic [W-1:0] A = 8'hF0;
   localparam logic [W-1:0] B = 8'h0F;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           train;
   logic [N*2*W-1:0] in_pairs;
   logic [N*2*W-1:0] out_pairs;
   logic [N-1:0]   out_valid;
   logic [N-1:0]   lock;
   logic [N-1:0]   err;

   int  checks = 0;
   int  errors = 0;
   int  ecnt   = 0;
   int  e  [N];
   int  eo [N];
   bit  mode = 1'b0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) ecnt <= 0;
      else        ecnt <= ecnt + 1;
   end

   pattern_word_aligner #(
      .STREAMS(N), .W(W), .LOCK_CNT(LC), .TIMEOUT(TO),
      .PAT_A(A), .PAT_B(B), .OUT_REG(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .train(train), .in_pairs(in_pairs),
      .out_pairs(out_pairs), .out_valid(out_valid), .lock(lock), .err(err)
   );

   function automatic logic [W-1:0] val(input int m, input bit pat);
      if (pat) return ((m % 4) < 2) ? A : B;
      return W'(16 + (m % 112));
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic drive();
      int n;
      n = 2 * (ecnt + 1);
      train = mode;
      for (int s = 0; s < N; s++) begin
         in_pairs[s*2*W +: W]     = val(n + e[s], mode);
         in_pairs[s*2*W + W +: W] = val(n + 1 + e[s], mode);
      end
   endtask

   task automatic step();
      @(negedge clk);
      drive();
   endtask

   function automatic logic [N-1:0] mask_eq(input int v);
      logic [N-1:0] r;
      for (int s = 0; s < N; s++) r[s] = (e[s] == v);
      return r;
   endfunction

   function automatic logic [N-1:0] mask_lockable();
      logic [N-1:0] r;
      for (int s = 0; s < N; s++) r[s] = (e[s] < 3);
      return r;
   endfunction

   task automatic chk_out(input string tag, input int J, input int d, input bit pat);
      for (int s = 0; s < N; s++) begin
         if (lock[s]) begin
            chk(tag, {out_pairs[s*2*W + W +: W], out_pairs[s*2*W +: W]},
                {val(2*J - 1 + d, pat), val(2*(J-1) + d, pat)});
         end
      end
   endtask

   initial begin
      int j0;
      int jd;
      int jc;
      int J;
      rst_n = 1'b0;
      train = 1'b0;
      in_pairs = '0;
      for (int s = 0; s < N; s++) e[s] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drive();
      step();
      step();
      chk("R1 lock after reset", 64'(lock), 64'(0));
      chk("R1 err after reset", 64'(err), 64'(0));
      chk("R1 out_valid after reset", 64'(out_valid), 64'(0));

      for (int r = 0; r < 4; r++) begin
         for (int s = 0; s < N; s++) e[s] = (s + r) % 4;
         mode = 1'b1;
         drive();
         j0 = ecnt + 1;
         while (ecnt < j0 + TO + 2) begin
            step();
            J = ecnt;
            if (J == j0) begin
               chk("R9 lock cleared", 64'(lock), 64'(0));
               chk("R9 err cleared", 64'(err), 64'(0));
            end
            if (J == j0 + LC - 1)
               chk("R3 no early lock", 64'(lock), 64'(0));
            if (J == j0 + LC)
               chk("R3 lock for zero skew", 64'(lock), 64'(mask_eq(0)));
            if (J == j0 + LC + 1) begin
               chk("R2 lock set by skew", 64'(lock), 64'(mask_lockable()));
               chk("R7 valid one edge after lock", 64'(out_valid), 64'(mask_eq(0)));
            end
            if (J >= j0 + LC + 2) begin
               chk("R7 valid follows lock", 64'(out_valid), 64'(lock));
               chk_out("R6 aligned test words", J, 0, 1'b1);
            end
            if (J == j0 + TO)
               chk("R4 no early err", 64'(err), 64'(0));
            if (J == j0 + TO + 1) begin
               chk("R4 err on timeout", 64'(err), 64'(mask_eq(3)));
               chk("R5 no lock with err", 64'(lock & err), 64'(0));
            end
         end

         mode = 1'b0;
         drive();
         jd = ecnt + 1;
         while (ecnt < jd + 8) begin
            step();
            J = ecnt;
            if (J >= jd + 2) begin
               chk("R5 valid only without err", 64'(out_valid), 64'(mask_lockable()));
               chk_out("R6 aligned data", J, 0, 1'b0);
            end
         end

         for (int s = 0; s < N; s++) begin
            eo[s] = e[s];
            e[s]  = (e[s] + 1) % 4;
         end
         drive();
         jc = ecnt + 1;
         while (ecnt < jc + 5) begin
            step();
            J = ecnt;
            if (J >= jc + 2) begin
               for (int s = 0; s < N; s++) begin
                  if (eo[s] < 3) begin
                     chk("R8 frozen offset",
                         {out_pairs[s*2*W + W +: W], out_pairs[s*2*W +: W]},
                         {val(2*J - 1 + e[s] - eo[s], 1'b0), val(2*(J-1) + e[s] - eo[s], 1'b0)});
                  end
               end
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule